// File: doc/BRIEF.md
# Wiper and Data Register Bank

This block holds the digital state behind a set of four digitally controlled potentiometers. Each channel has one volatile wiper register, whose value is presented on the output as the wiper code. Each channel also has four data registers that stand in for nonvolatile storage and are built from flip-flops. Requests reach the bank from two decoded sources. A serial slave front end delivers byte-level operations: select a row and mode, set the channel pointer, write a data byte, or end the transfer. An up/down front end delivers single steps and store requests for one selected channel.

Selecting a data row copies that row into every wiper in one cycle. A data byte written in data mode lands in the wiper straight away and is staged for the data register. The staged bytes are committed when the transfer ends, but only if write protect permits. Each commit, whether from the serial path or from an up/down store, starts a self-timed busy window. During that window the bank ignores every request. After reset the bank spends one cycle copying row 0 into the wipers before it reports ready.

Top module: `wdr_bank`

## Requirements
- R1: While reset is held, `ready` is 0 and all wipers read 0. On the first clock after reset is released, each wiper takes row 0 of its channel's data registers (reset value `DR_INIT`, channel c in bits [8c+7:8c]; rows 1 to 3 reset to 0), and `ready` rises and stays high.
- R2: A serial request with op 0 (select) takes mode from data bit 0 and row from data bits [2:1]. If the mode bit is 1, all four wipers take their channel's data register of that row in the same cycle. If the mode bit is 0, the wipers are unchanged.
- R3: Op 1 (pointer) loads the channel pointer from data bits [1:0]. Op 2 (data) writes the byte into the pointed wiper only and leaves the other three unchanged. The pointer then advances by one and wraps from channel 3 to channel 0.
- R4: In data mode, an op 2 byte is also staged for the pointed channel in the selected row; a later byte to the same channel replaces it. Any select request discards all staged bytes.
- R5: Op 3 (end) with at least one staged byte and `wp`=1 writes the staged bytes into the selected row and leaves unstaged channels unchanged. `busy` is then high for exactly `COMMIT_CYC` cycles, starting the cycle after the request. Op 3 with nothing staged starts no busy window.
- R6: Op 3 with `wp`=0 discards the staged bytes without changing any data register and starts no busy window.
- R7: `ud_step` moves the wiper of channel `ud_sel` up by one when `ud_up`=1 and down by one otherwise. The wiper saturates at 255 and at 0.
- R8: `ud_store` with `wp`=1 copies the wiper of channel `ud_sel` into that channel's row 0 data register and starts a busy window. With `wp`=0 it has no effect. If store and step coincide, the store is taken.
- R9: While `busy` is high or `ready` is low, every serial and up/down request is ignored.
- R10: When a serial request and an up/down request arrive in the same cycle, the serial request is served and the up/down request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Write permit for commits; 0 blocks them |
| tw_valid | input | 1 | Serial request strobe |
| tw_op | input | 2 | Serial op: 0 select, 1 pointer, 2 data, 3 end |
| tw_data | input | 8 | Serial operand byte |
| ud_step | input | 1 | Up/down step strobe |
| ud_up | input | 1 | Step direction, 1 = up |
| ud_sel | input | 2 | Up/down channel select |
| ud_store | input | 1 | Up/down store strobe |
| wiper | output | 32 | Four wiper codes, channel c at [8c+7:8c] |
| busy | output | 1 | Commit window active |
| ready | output | 1 | Power-up recall done |

## Verification
A serial request and an up/down step or store can land in the same cycle. The serial one must win, and the up/down one must leave no trace. The bench provokes this both directly and through random stimulus, where the step and store strobes are drawn on their own alongside the serial strobe. A bench model drops the up/down side whenever the serial strobe is set. Every cycle, it compares all four wipers and the busy flag against the bank's outputs. Data registers are observed by selecting their row in data mode and reading the wipers.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
    typedef enum logic [1:0] {
        OP_SEL  = 2'd0,
        OP_ADDR = 2'd1,
        OP_DATA = 2'd2,
        OP_STOP = 2'd3
    } tw_op_e;
endpackage

// File: rtl/wdr_busy_timer.sv
module wdr_busy_timer #(
    parameter int CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNTW = $clog2(CYC + 1);

    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CNTW'(CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    a_r5_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/wdr_step.sv
module wdr_step #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cur,
    input  logic          up,
    output logic [DW-1:0] nxt
);
    localparam logic [DW-1:0] TOP = '1;

    always_comb begin
        if (up) nxt = (cur == TOP) ? cur : cur + 1'b1;
        else    nxt = (cur == '0)  ? cur : cur - 1'b1;
    end
endmodule

// File: rtl/wdr_bank.sv
module wdr_bank
    import wdr_pkg::*;
#(
    parameter int              CH         = 4,
    parameter int              ROWS       = 4,
    parameter int              DW         = 8,
    parameter int              COMMIT_CYC = 20,
    parameter logic [CH*DW-1:0] DR_INIT   = 32'h80C0_4010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp,
    input  logic             tw_valid,
    input  logic [1:0]       tw_op,
    input  logic [7:0]       tw_data,
    input  logic             ud_step,
    input  logic             ud_up,
    input  logic [1:0]       ud_sel,
    input  logic             ud_store,
    output logic [CH*DW-1:0] wiper,
    output logic             busy,
    output logic             ready
);
    localparam int CW = $clog2(CH);
    localparam int RW = $clog2(ROWS);
    localparam logic [DW-1:0] TOP = '1;

    typedef struct packed {
        logic [CH-1:0][DW-1:0]           wcr;
        logic [CH-1:0][ROWS-1:0][DW-1:0] dr;
        logic [CH-1:0][DW-1:0]           pend;
        logic [CH-1:0]                   pend_v;
        logic [RW-1:0]                   row;
        logic                            nv;
        logic [CW-1:0]                   ptr;
        logic                            ready;
    } bank_t;

    bank_t          st_d, st_q;
    logic           start;
    logic [DW-1:0]  step_val;
    logic [RW-1:0]  row_new;
    tw_op_e         op;

    assign op = tw_op_e'(tw_op);

    wdr_step #(.DW(DW)) u_step (
        .cur (st_q.wcr[ud_sel[CW-1:0]]),
        .up  (ud_up),
        .nxt (step_val)
    );

    wdr_busy_timer #(.CYC(COMMIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    always_comb begin
        st_d    = st_q;
        start   = 1'b0;
        row_new = tw_data[RW:1];
        if (!st_q.ready) begin
            for (int c = 0; c < CH; c++) st_d.wcr[c] = st_q.dr[c][0];
            st_d.ready = 1'b1;
        end else if (!busy) begin
            if (tw_valid) begin
                case (op)
                    OP_SEL: begin
                        st_d.nv     = tw_data[0];
                        st_d.row    = row_new;
                        st_d.pend_v = '0;
                        if (tw_data[0])
                            for (int c = 0; c < CH; c++) st_d.wcr[c] = st_q.dr[c][row_new];
                    end
                    OP_ADDR: st_d.ptr = tw_data[CW-1:0];
                    OP_DATA: begin
                        st_d.wcr[st_q.ptr] = tw_data[DW-1:0];
                        if (st_q.nv) begin
                            st_d.pend[st_q.ptr]   = tw_data[DW-1:0];
                            st_d.pend_v[st_q.ptr] = 1'b1;
                        end
                        st_d.ptr = st_q.ptr + 1'b1;
                    end
                    default: begin
                        if (|st_q.pend_v) begin
                            if (wp) begin
                                for (int c = 0; c < CH; c++)
                                    if (st_q.pend_v[c]) st_d.dr[c][st_q.row] = st_q.pend[c];
                                start = 1'b1;
                            end
                            st_d.pend_v = '0;
                        end
                    end
                endcase
            end else if (ud_store) begin
                if (wp) begin
                    st_d.dr[ud_sel[CW-1:0]][0] = st_q.wcr[ud_sel[CW-1:0]];
                    start = 1'b1;
                end
            end else if (ud_step) begin
                st_d.wcr[ud_sel[CW-1:0]] = step_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int c = 0; c < CH; c++) st_q.dr[c][0] <= DR_INIT[c*DW +: DW];
        end else begin
            st_q <= st_d;
        end
    end

    assign wiper = st_q.wcr;
    assign ready = st_q.ready;

    a_r1_ready_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);
    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    a_r9_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wiper));
    a_r6_no_commit_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy && tw_valid && tw_op == 2'd3 && !wp) |=> !busy);
    a_r10_serial_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy && tw_valid && tw_op == 2'd0 && !tw_data[0] && (ud_step || ud_store))
        |=> ($stable(wiper) && !busy));
    a_r7_saturate_top: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy && !tw_valid && !ud_store && ud_step && ud_up
         && st_q.wcr[ud_sel[CW-1:0]] == TOP) |=> $stable(wiper));
endmodule

// File: tb/wdr_bank_test.sv
`timescale 1ns/1ps
module wdr_bank_test;
    localparam int          CYC  = 20;
    localparam logic [31:0] INIT = 32'h80C0_4010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp = 1'b1;
    logic        tw_valid = 1'b0;
    logic [1:0]  tw_op = '0;
    logic [7:0]  tw_data = '0;
    logic        ud_step = 1'b0, ud_up = 1'b0, ud_store = 1'b0;
    logic [1:0]  ud_sel = '0;
    logic [31:0] wiper;
    logic        busy, ready;

    int checks = 0, errors = 0;
    logic [7:0] m_dr [4][4];
    logic [7:0] m_wcr [4];
    logic [7:0] m_pd [4];
    logic       m_pv [4];
    logic [1:0] m_row, m_ptr;
    logic       m_nv;
    int         m_busy = 0;
    bit         done = 0;

    wdr_bank #(.COMMIT_CYC(CYC), .DR_INIT(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .wp(wp), .tw_valid(tw_valid), .tw_op(tw_op),
        .tw_data(tw_data), .ud_step(ud_step), .ud_up(ud_up), .ud_sel(ud_sel),
        .ud_store(ud_store), .wiper(wiper), .busy(busy), .ready(ready));

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_wiper();
        return {m_wcr[3], m_wcr[2], m_wcr[1], m_wcr[0]};
    endfunction

    function automatic logic [7:0] sat_step(logic [7:0] v, logic up);
        if (up) return (v == 8'hFF) ? v : v + 8'd1;
        return (v == 8'h00) ? v : v - 8'd1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string pick_tag(logic v, logic [1:0] op, logic st, logic sto);
        if (m_busy > 0) return "R9";
        if (v && (st || sto)) return "R10";
        if (v) case (op)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return m_nv ? "R4" : "R3";
            default: return wp ? "R5" : "R6";
        endcase
        if (sto) return "R8";
        return "R7";
    endfunction

    task automatic model(logic v, logic [1:0] op, logic [7:0] d, logic st, logic up,
                         logic [1:0] sel, logic sto, logic w);
        if (m_busy > 0) begin m_busy--; return; end
        if (v) begin
            case (op)
                2'd0: begin
                    m_nv = d[0]; m_row = d[2:1];
                    for (int c = 0; c < 4; c++) begin
                        m_pv[c] = 0;
                        if (d[0]) m_wcr[c] = m_dr[c][d[2:1]];
                    end
                end
                2'd1: m_ptr = d[1:0];
                2'd2: begin
                    m_wcr[m_ptr] = d;
                    if (m_nv) begin m_pd[m_ptr] = d; m_pv[m_ptr] = 1; end
                    m_ptr = m_ptr + 2'd1;
                end
                default: begin
                    if (m_pv[0] || m_pv[1] || m_pv[2] || m_pv[3]) begin
                        if (w) begin
                            for (int c = 0; c < 4; c++) if (m_pv[c]) m_dr[c][m_row] = m_pd[c];
                            m_busy = CYC;
                        end
                        for (int c = 0; c < 4; c++) m_pv[c] = 0;
                    end
                end
            endcase
        end else if (sto) begin
            if (w) begin m_dr[sel][0] = m_wcr[sel]; m_busy = CYC; end
        end else if (st) begin
            m_wcr[sel] = sat_step(m_wcr[sel], up);
        end
    endtask

    task automatic tick(logic v, logic [1:0] op, logic [7:0] d, logic st, logic up,
                        logic [1:0] sel, logic sto, logic w);
        string tag;
        tag = pick_tag(v, op, st, sto);
        tw_valid = v; tw_op = op; tw_data = d; ud_step = st; ud_up = up;
        ud_sel = sel; ud_store = sto; wp = w;
        @(posedge clk);
        model(v, op, d, st, up, sel, sto, w);
        @(negedge clk);
        tw_valid = 0; ud_step = 0; ud_store = 0;
        check({tag, " wiper"}, wiper, exp_wiper());
        check({tag, " busy"}, {31'd0, busy}, {31'd0, m_busy > 0});
    endtask

    task automatic tw(logic [1:0] op, logic [7:0] d, logic w = 1);
        tick(1, op, d, 0, 0, 0, 0, w);
    endtask

    task automatic wait_idle();
        while (m_busy > 0) tick(0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
    end

    initial begin
        int hi;
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) m_dr[c][r] = (r == 0) ? INIT[c*8 +: 8] : 8'h00;
            m_wcr[c] = 0; m_pv[c] = 0; m_pd[c] = 0;
        end
        m_row = 0; m_ptr = 0; m_nv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready in reset", {31'd0, ready}, 32'd0);
        check("R1 wiper in reset", wiper, 32'd0);
        rst_n = 1;
        @(negedge clk);
        for (int c = 0; c < 4; c++) m_wcr[c] = m_dr[c][0];
        check("R1 ready after recall", {31'd0, ready}, 32'd1);
        check("R1 wiper after recall", wiper, INIT);

        // R3 individual wiper writes with pointer wrap
        tw(2'd1, 8'h03);
        tw(2'd2, 8'hA3);
        tw(2'd2, 8'hA0);
        // R5 page write into row 2 with rollover, then commit
        tw(2'd0, 8'h05);
        tw(2'd2, 8'h99);
        tw(2'd0, 8'h05);
        tw(2'd1, 8'h02);
        tw(2'd2, 8'h22); tw(2'd2, 8'h32); tw(2'd2, 8'h02);
        tw(2'd3, 8'h00, 1);
        hi = 0;
        while (busy) begin tick(0, 0, 0, 1, 1, 1, 0, 1); hi++; end
        check("R5 busy length", hi, CYC);
        tw(2'd0, 8'h00);
        tw(2'd0, 8'h05);
        check("R5 row 2 readback", wiper, 32'h3222_0002);
        // R6 protected discard
        tw(2'd1, 8'h00);
        tw(2'd2, 8'h77);
        tw(2'd3, 8'h00, 0);
        tw(2'd0, 8'h05);
        check("R6 row 2 unchanged", wiper, 32'h3222_0002);
        // R7 saturation at both ends
        tw(2'd0, 8'h00); tw(2'd1, 8'h01); tw(2'd2, 8'hFE);
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 1, 1, 1, 0, 1);
        check("R7 top saturation", {24'd0, wiper[15:8]}, 32'hFF);
        tw(2'd1, 8'h01); tw(2'd2, 8'h01);
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 1, 0, 1, 0, 1);
        check("R7 bottom saturation", {24'd0, wiper[15:8]}, 32'h00);
        // R8 store then R10 collision
        tick(0, 0, 0, 1, 1, 3, 1, 0);
        tick(0, 0, 0, 0, 0, 3, 1, 1);
        wait_idle();
        tick(1, 2'd0, 8'h00, 1, 1, 2, 0, 1);
        tick(1, 2'd0, 8'h00, 0, 0, 2, 1, 1);

        // random phase
        for (int i = 0; i < 3000 && !done; i++) begin
            logic v, st, sto;
            v   = ($urandom % 3) != 0;
            st  = ($urandom % 3) == 0;
            sto = ($urandom % 23) == 0;
            tick(v, 2'($urandom), 8'($urandom), st, 1'($urandom), 2'($urandom), sto,
                 ($urandom % 4) != 0);
        end
        wait_idle();
        for (int r = 0; r < 4; r++) begin
            tw(2'd0, 8'(r * 2 + 1));
            check("R2 final row readback", wiper,
                  {m_dr[3][r], m_dr[2][r], m_dr[1][r], m_dr[0][r]});
        end
        done = 1;
    end

    initial begin
        wait (done);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule